// File: doc/BRIEF.md
# Finite-Difference Integer Cube Root

This unit returns the floor of the cube root of an unsigned integer operand, using only adders, subtractors and comparators. It works like the familiar square root that removes successive odd numbers from its input, but for cubes. It removes the gaps between consecutive cubes, 1, 7, 19, 37, 61 and so on, one gap per clock. It stops when what remains of the operand is smaller than the next gap. The number of gaps removed is the root.

Two cascaded accumulators produce the gaps. The first holds the gap to be removed next, which is 3c²+3c+1 after c removals. The second holds the amount the first grows by, which is 6(c+1) and rises by a constant 6 per step. A caller pulses `start` with the operand while the unit is idle. `busy` stays high while removals continue. `done` pulses for one cycle when the root is ready on `root`. A root r takes r cycles after the start edge, so a zero operand finishes in the cycle after start.

Top module: `cbrt_fd_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `root` is 0.
- R2: For every W-bit operand, the `root` presented with `done` is the largest r with r³ ≤ operand.
- R3: After c removals the gap to remove next is 3c²+3c+1, and the second accumulator holds 6(c+1).
- R4: An operand of 0 gives `done` high with `root` 0 in the cycle right after the clock edge that samples `start`.
- R5: For a root r, `done` goes high r cycles after the edge that samples `start`.
- R6: `done` lasts one cycle unless a new start lands in that same cycle. `busy` and `done` are never high together. For a nonzero operand, `busy` is high from the cycle after the start edge until `done`.
- R7: A `start` pulse while `busy` is high is ignored: the running result and its latency stay those of the first operand.
- R8: `root` keeps its value in every cycle where `done` is low.
- R9: The largest operand, 2^W−1, gives root 1625 for W=32, and neither accumulator overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only while idle |
| operand | input | W | Unsigned value whose cube root is taken |
| busy | output | 1 | Removal steps in progress |
| done | output | 1 | One-cycle pulse: result ready |
| root | output | RW | Floor of the cube root, held between results |

## Verification
Exact cubes and their predecessors (0, 1, 7, 8, 26, 27, 63, 64, 1625³−1, 1625³) separate a correct stopping test from an off-by-one ≥/> comparison. The all-ones operand exposes accumulator overflow and the longest latency. Random operands, shifted by a random amount so that their roots range from 0 to the maximum, compare root and latency with a reference search in the bench. A start pulse during a long run shows whether the operand is captured again while busy.

// File: rtl/cbrt_pkg.sv
package cbrt_pkg;
    typedef enum logic [0:0] {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

    function automatic int unsigned root_bits(input int unsigned w);
        return (w + 2) / 3;
    endfunction
endpackage

// File: rtl/cbrt_diff_gen.sv
module cbrt_diff_gen #(
    parameter int unsigned RW  = 11,
    parameter int unsigned D1W = 2 * RW + 3,
    parameter int unsigned D2W = RW + 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           advance,
    output logic [D1W-1:0] gap,
    output logic [D2W-1:0] slope
);
    typedef struct packed {
        logic [D1W-1:0] gap;
        logic [D2W-1:0] slope;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [D1W-1:0] gap_base;
    logic [D2W-1:0] slope_base;

    always_comb begin
        gap_base   = load ? D1W'(1) : acc_q.gap;
        slope_base = load ? D2W'(6) : acc_q.slope;
        acc_d.gap   = gap_base;
        acc_d.slope = slope_base;
        if (advance) begin
            acc_d.gap   = gap_base + D1W'(slope_base);
            acc_d.slope = slope_base + D2W'(6);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.gap   <= D1W'(1);
            acc_q.slope <= D2W'(6);
        end else begin
            acc_q <= acc_d;
        end
    end

    assign gap   = acc_q.gap;
    assign slope = acc_q.slope;

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_q.gap[D1W-1] && !acc_q.slope[D2W-1]);
endmodule

// File: rtl/cbrt_ctrl.sv
module cbrt_ctrl
    import cbrt_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned RW  = 11,
    parameter int unsigned D1W = 2 * RW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   operand,
    input  logic [D1W-1:0] gap,
    output logic           load,
    output logic           advance,
    output logic           busy,
    output logic           done,
    output logic [RW-1:0]  count,
    output logic [RW-1:0]  result
);
    localparam int unsigned CW = (W > D1W) ? W : D1W;

    typedef struct packed {
        phase_e        phase;
        logic [W-1:0]  rem;
        logic [RW-1:0] count;
        logic [RW-1:0] result;
        logic          done;
    } ctl_t;

    ctl_t s_d, s_q;
    logic [CW-1:0] rem_w, gap_w, diff_w;

    always_comb begin
        rem_w   = CW'(s_q.rem);
        gap_w   = CW'(gap);
        diff_w  = rem_w - gap_w;
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = 1'b0;
        advance  = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (operand != '0) begin
                        advance   = 1'b1;
                        s_d.rem   = operand - W'(1);
                        s_d.count = RW'(1);
                        s_d.phase = PH_RUN;
                    end else begin
                        s_d.count  = '0;
                        s_d.result = '0;
                        s_d.done   = 1'b1;
                    end
                end
            end
            default: begin
                if (rem_w >= gap_w) begin
                    advance   = 1'b1;
                    s_d.rem   = W'(diff_w);
                    s_d.count = s_q.count + RW'(1);
                end else begin
                    s_d.result = s_q.count;
                    s_d.done   = 1'b1;
                    s_d.phase  = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= PH_IDLE;
            s_q.rem    <= '0;
            s_q.count  <= '0;
            s_q.result <= '0;
            s_q.done   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.phase == PH_RUN);
    assign done   = s_q.done;
    assign count  = s_q.count;
    assign result = s_q.result;

    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);
    p_root_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
    p_busy_keeps_going_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> (busy && count == $past(count) + RW'(1)) || done);
endmodule

// File: rtl/cbrt_fd_unit.sv
module cbrt_fd_unit
    import cbrt_pkg::*;
#(
    parameter int unsigned W   = 32,
    parameter int unsigned RW  = root_bits(W),
    parameter int unsigned D1W = 2 * RW + 3,
    parameter int unsigned D2W = RW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  operand,
    output logic          busy,
    output logic          done,
    output logic [RW-1:0] root
);
    logic           load, advance;
    logic [D1W-1:0] gap;
    logic [D2W-1:0] slope;
    logic [RW-1:0]  count;

    cbrt_ctrl #(.W(W), .RW(RW), .D1W(D1W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .gap     (gap),
        .load    (load),
        .advance (advance),
        .busy    (busy),
        .done    (done),
        .count   (count),
        .result  (root)
    );

    cbrt_diff_gen #(.RW(RW), .D1W(D1W), .D2W(D2W)) u_diff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .gap     (gap),
        .slope   (slope)
    );

    p_slope_tracks_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(slope) == 32'd6 * (32'(count) + 32'd1)));
    p_gap_tracks_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (64'(gap) == 64'd3 * 64'(count) * 64'(count) + 64'd3 * 64'(count) + 64'd1));
endmodule

// File: tb/cbrt_fd_unit_tb.sv
module cbrt_fd_unit_tb;
    localparam int unsigned W  = 32;
    localparam int unsigned RW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  operand = '0;
    logic          busy, done;
    logic [RW-1:0] root;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cbrt_fd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .busy(busy), .done(done), .root(root)
    );

    function automatic int unsigned ref_root(input longint unsigned x);
        longint unsigned r = 0;
        while ((r + 1) * (r + 1) * (r + 1) <= x) r++;
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [W-1:0] x, input bit poke);
        int unsigned exp_r = ref_root(longint'(x));
        int n = 0;
        logic [RW-1:0] held;
        @(negedge clk);
        start = 1'b1;
        operand = x;
        @(posedge clk);
        #2;
        start = 1'b0;
        if (exp_r > 0) check(busy == 1'b1, "R6 busy after start", busy, 1);
        while (!done && n < 3000) begin
            if (poke && n == 1) begin
                start = 1'b1;
                operand = '0;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            #2;
            n++;
        end
        start = 1'b0;
        operand = x;
        check(root == RW'(exp_r), "R2 root", root, exp_r);
        check(n == int'(exp_r), poke ? "R7 latency with start poke" : "R5 latency", n, exp_r);
        check(busy == 1'b0, "R6 busy low at done", busy, 0);
        if (x == 0) check(n == 0 && root == 0, "R4 zero operand", n, 0);
        held = root;
        @(posedge clk);
        #2;
        check(done == 1'b0, "R6 done one cycle", done, 0);
        check(root == held, "R8 root held", root, held);
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd1357));
        #3;
        check(busy == 0 && done == 0 && root == 0, "R1 reset state", {busy, done, 11'(root)}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 zero, R2/R5 exact cubes and neighbours
        run(32'd0, 1'b0);
        run(32'd1, 1'b0);
        run(32'd7, 1'b0);
        run(32'd8, 1'b0);
        run(32'd26, 1'b0);
        run(32'd27, 1'b0);
        run(32'd63, 1'b0);
        run(32'd64, 1'b0);
        run(32'd4291015624, 1'b0);
        run(32'd4291015625, 1'b0);
        // R9 largest operand
        run(32'hFFFF_FFFF, 1'b0);
        check(root == 11'd1625, "R9 max root", root, 1625);
        // R7 start while busy
        run(32'd1000000, 1'b1);
        run(32'd300, 1'b1);
        // R2/R5 random operands across the root range
        for (int i = 0; i < 40; i++) begin
            v = $urandom() >> ($urandom() % 32);
            run(v, 1'b0);
        end
        // back-to-back zeros: done may repeat when start lands in the done cycle
        run(32'd0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule